// File: doc/BRIEF.md
# Chainable Serial Result Port for a 14-bit Converter

This block is the digital readout side of a 14-bit sampling converter. Several of these converters can share one three-wire serial bus by being wired in a daisy chain. A host raises the conversion strobe (`cnv_i`) while the serial clock (`sck_i`) is low. That edge starts a conversion and selects chain operation. The analog part is stood in for by a counter that runs for `CONV_CYCLES` system clocks. When the counter expires, the result word on `sample_i` is captured into a shift register, and its most significant bit is placed on `sdo_o` before any clock edge arrives.

Each falling edge of the serial clock then moves the next bit onto `sdo_o`, most significant bit first. At the same edge, the level on `sdi_i` enters at the low end of the register. A device further up the chain connects its `sdo_o` to this device's `sdi_i`, so its word follows this device's word out of `sdo_o`. Reading N devices takes 14·N falling edges. Dropping `cnv_i` ends the readback.

`cnv_i`, `sck_i` and `sdi_i` are asynchronous to `clk`. Each passes through its own two-stage synchroniser, and edges are found by comparing the synchronised level with its value one clock earlier.

Top module: `chain_adc_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sdo_o` is 0 and the block is idle.
- R2: While no readback is active, `sdo_o` stays 0 whatever `sdi_i` does. This covers the idle case with `cnv_i` low.
- R3: A rise of `cnv_i` is seen 2 clocks after the input changes, through the synchroniser. If synchronised `sck_i` is low at that moment, the rise starts a conversion lasting `CONV_CYCLES` clocks. `sdo_o` stays 0 during the conversion.
- R4: A rise of `cnv_i` while synchronised `sck_i` is high starts nothing: `sdo_o` stays 0 for as long as `cnv_i` stays high.
- R5: At the end of the conversion, `sample_i` is captured. Its bit 13 appears on `sdo_o` in the next cycle, without any `sck_i` edge.
- R6: During readback, each falling edge of `sck_i` moves the next lower result bit onto `sdo_o`. Rising edges move nothing.
- R7: The level of `sdi_i` at each `sck_i` falling edge enters the low end of the register. After 14 falling edges, `sdo_o` presents those `sdi_i` bits in arrival order.
- R8: Falling edges of `sck_i` during the conversion are ignored. A later readback still starts with bit 13 of the captured word.
- R9: A fall of `cnv_i` during a conversion or a readback returns the block to idle, and `sdo_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Conversion strobe, asynchronous; held high through conversion and readback |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data from the upstream device in the chain |
| sample_i | input | 14 | Result word captured when the conversion counter expires |
| sdo_o | output | 1 | Serial data toward the host or the downstream device |

## Verification
The hardest case to reach is the one where serial clock edges arrive while the conversion counter is still running. A wrong design would then shift bits away before they are ever loaded, and the damage only shows up later as a corrupted first bit of the readback. The stimulus toggles `sck_i` several times in the middle of a conversion and then reads a word whose top bits differ. A second hard case is a conversion aborted by dropping `cnv_i` before the counter ends; the bench waits well past the conversion time to confirm that no late load appears on `sdo_o`. A rise of `cnv_i` taken while `sck_i` is high is checked over the same long window.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } chain_state_e;

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cps_timer.sv
module cps_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (abort_i) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/cps_shift.sv
module cps_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  always_comb begin
    if (load_i)       nxt_o = word_i;
    else if (shift_i) nxt_o = {q[W-2:0], sin_i};
    else              nxt_o = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
  import chain_port_pkg::*;
#(
  parameter int W           = 14,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnv_i,
  input  logic         sck_i,
  input  logic         sdi_i,
  input  logic [W-1:0] sample_i,
  output logic         sdo_o
);
  localparam int NSYNC = 3;
  localparam int B_CNV = 0;
  localparam int B_SCK = 1;
  localparam int B_SDI = 2;

  logic [NSYNC-1:0] raw_in, syn;
  logic             cnv_s, sck_s, sdi_s;
  logic             cnv_p, sck_p;
  logic             cnv_rise, cnv_fall, sck_fall;
  logic             conv_done, tmr_start, tmr_abort;
  logic             sh_load, sh_shift;
  logic [W-1:0]     sh_q, sh_nxt;
  chain_state_e     state_q, st_n;
  logic             sdo_q;

  assign raw_in[B_CNV] = cnv_i;
  assign raw_in[B_SCK] = sck_i;
  assign raw_in[B_SDI] = sdi_i;

  cps_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn)
  );

  assign cnv_s = syn[B_CNV];
  assign sck_s = syn[B_SCK];
  assign sdi_s = syn[B_SDI];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_p <= 1'b0;
      sck_p <= 1'b0;
    end else begin
      cnv_p <= cnv_s;
      sck_p <= sck_s;
    end
  end

  assign cnv_rise =  cnv_s & ~cnv_p;
  assign cnv_fall = ~cnv_s &  cnv_p;
  assign sck_fall = ~sck_s &  sck_p;

  cps_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_i(tmr_start), .abort_i(tmr_abort),
    .done_o(conv_done)
  );

  cps_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .load_i(sh_load), .word_i(sample_i),
    .shift_i(sh_shift), .sin_i(sdi_s), .q_o(sh_q), .nxt_o(sh_nxt)
  );

  always_comb begin
    st_n      = state_q;
    tmr_start = 1'b0;
    tmr_abort = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cnv_rise && !sck_s) begin
          st_n      = ST_CONV;
          tmr_start = 1'b1;
        end
      end
      ST_CONV: begin
        if (cnv_fall) begin
          st_n      = ST_IDLE;
          tmr_abort = 1'b1;
        end else if (conv_done) begin
          st_n    = ST_READ;
          sh_load = 1'b1;
        end
      end
      ST_READ: begin
        if (cnv_fall)      st_n     = ST_IDLE;
        else if (sck_fall) sh_shift = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sdo_q   <= 1'b0;
    end else begin
      state_q <= st_n;
      sdo_q   <= (st_n == ST_READ) && sh_nxt[W-1];
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/chain_adc_port_chk.sv
module chain_adc_port_chk
  import chain_port_pkg::*;
#(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         sdo_o,
  input logic [W-1:0] sample_i,
  input chain_state_e state_q,
  input logic         cnv_rise,
  input logic         cnv_fall,
  input logic         sck_s,
  input logic         sck_fall,
  input logic         sdi_s,
  input logic         conv_done,
  input logic [W-1:0] sh_q
);
  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> (!sdo_o && state_q == ST_IDLE))
    else $error("p_rst_quiet_r1");

  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_READ) |-> !sdo_o)
    else $error("p_idle_low_r2");

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cnv_rise && !sck_s) |=> (state_q == ST_CONV))
    else $error("p_start_r3");

  p_no_start_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && sck_s) |=> (state_q == ST_IDLE))
    else $error("p_no_start_r4");

  p_load_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && conv_done && !cnv_fall) |=> (sdo_o == $past(sample_i[W-1])))
    else $error("p_load_msb_r5");

  p_shift_in_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && sck_fall && !cnv_fall) |=>
      (sh_q == {$past(sh_q[W-2:0]), $past(sdi_s)}))
    else $error("p_shift_in_r7");

  p_conv_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && !conv_done) |=> $stable(sh_q))
    else $error("p_conv_hold_r8");

  p_end_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && cnv_fall) |=> (state_q == ST_IDLE && !sdo_o))
    else $error("p_end_r9");
endmodule

bind chain_adc_port chain_adc_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sdo_o(sdo_o), .sample_i(sample_i),
  .state_q(state_q), .cnv_rise(cnv_rise), .cnv_fall(cnv_fall),
  .sck_s(sck_s), .sck_fall(sck_fall), .sdi_s(sdi_s),
  .conv_done(conv_done), .sh_q(sh_q)
);

// File: tb/chain_adc_port_test.sv
module chain_adc_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 14;
  localparam int CONV       = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [W-1:0] sample = '0;
  logic         sdo;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  chain_adc_port #(.W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
    .sample_i(sample), .sdo_o(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: 0 idle, 1 converting, 2 reading
  int   m_st = 0;
  int   m_cnt = 0;
  bit   m_q[$];
  bit   m_sdo = 0;
  bit   c1 = 0, c2 = 0, cp = 0, k1 = 0, k2 = 0, kp = 0, d1 = 0, d2 = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_q.delete(); m_sdo = 0;
      c1 = 0; c2 = 0; cp = 0; k1 = 0; k2 = 0; kp = 0; d1 = 0; d2 = 0;
    end else begin
      bit rise, fall, kfall;
      rise  = c2 && !cp;
      fall  = !c2 && cp;
      kfall = !k2 && kp;
      case (m_st)
        0: if (rise && !k2) begin m_st = 1; m_cnt = CONV - 1; end
        1: begin
          if (fall) m_st = 0;
          else if (m_cnt == 0) begin
            m_st = 2;
            m_q.delete();
            for (int b = W-1; b >= 0; b--) m_q.push_back(sample[b]);
          end else m_cnt--;
        end
        default: begin
          if (fall) m_st = 0;
          else if (kfall) begin
            void'(m_q.pop_front());
            m_q.push_back(d2);
          end
        end
      endcase
      m_sdo = (m_st == 2) ? m_q[0] : 1'b0;
      cp = c2; c2 = c1; c1 = cnv;
      kp = k2; k2 = k1; k1 = sck;
      d2 = d1; d1 = sdi;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (sdo !== m_sdo) begin
        failures++;
        $display("FAIL %s per-cycle sdo actual=%b expected=%b t=%0t",
                 (m_st == 0) ? "R2" : (m_st == 1) ? "R3" : "R6", sdo, m_sdo, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse(input logic din);
    sck = 1'b1; cyc(3);
    sck = 1'b0; sdi = din; cyc(4);
  endtask

  task automatic read_word(input logic [W-1:0] exp, input logic [W-1:0] pat);
    for (int i = 0; i < W; i++) begin
      chk(i == 0 ? "R5" : "R6", sdo, exp[W-1-i]);
      sck_pulse(pat[i]);
    end
    for (int i = 0; i < 3; i++) begin
      chk("R7", sdo, pat[i]);
      sck_pulse(1'b0);
    end
  endtask

  initial begin
    cyc(3);
    chk("R1", sdo, 1'b0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", sdo, 1'b0);

    // R2: idle, SDI toggles, SDO stays low
    for (int i = 0; i < 10; i++) begin
      sdi = ~sdi; cyc(2);
      chk("R2", sdo, 1'b0);
    end
    sdi = 1'b0;

    // R3/R8/R5/R6/R7: full conversion with SCK noise during conversion
    sample = 14'h2A5C;
    cnv = 1'b1; cyc(CONV / 2);
    chk("R3", sdo, 1'b0);
    sample = 14'h3A5C;
    for (int i = 0; i < 3; i++) sck_pulse(1'b1);
    sdi = 1'b0;
    cyc(CONV);
    read_word(14'h3A5C, 14'h1B35);
    cnv = 1'b0; cyc(5);
    chk("R9", sdo, 1'b0);

    // second word, all ones, chained SDI zeros
    sample = 14'h3FFF;
    cnv = 1'b1; cyc(CONV + 6);
    read_word(14'h3FFF, 14'h0000);
    cnv = 1'b0; cyc(5);
    chk("R9", sdo, 1'b0);

    // R4: CNV rise while SCK high
    sample = 14'h3FFF;
    sck = 1'b1; cyc(4);
    cnv = 1'b1; cyc(CONV + 10);
    chk("R4", sdo, 1'b0);
    sck = 1'b0; cyc(CONV + 10);
    chk("R4", sdo, 1'b0);
    cnv = 1'b0; cyc(5);

    // R9: abort during conversion
    cnv = 1'b1; cyc(CONV / 2);
    cnv = 1'b0; cyc(CONV + 10);
    chk("R9", sdo, 1'b0);

    // R9: readback ended mid-word, then fresh conversion starts at MSB
    sample = 14'h2001;
    cnv = 1'b1; cyc(CONV + 6);
    chk("R5", sdo, 1'b1);
    sck_pulse(1'b1);
    chk("R6", sdo, 1'b0);
    cnv = 1'b0; cyc(5);
    chk("R9", sdo, 1'b0);
    sample = 14'h2000;
    cnv = 1'b1; cyc(CONV + 6);
    read_word(14'h2000, 14'h2AAA);
    cnv = 1'b0; cyc(5);
    chk("R2", sdo, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule